// File: doc/BRIEF.md
# Frequency-Domain Phase Detector and Tuning Path for a Digital PLL

This block is the digital front end of an all-digital frequency synthesizer. It has no divider and no charge pump. It samples a free-running count of oscillator edges together with a fractional code from a time-to-digital converter. From these it forms a fixed-point oscillator phase.

On each reference strobe the block differences that phase against the previous sample to obtain the measured frequency. It subtracts the requested frequency word and accumulates the difference, which recovers the phase error.

A proportional-integral filter with shift-selected gains turns the phase error into a tuning word. The tuning word is split into a coarse capacitor-bank code and a fractional remainder. A first-order delta-sigma modulator dithers that remainder into a 0/1 carry. The modulator runs on every cycle of the fast block clock, and the loop itself advances only on reference strobes.

Top module: `adpll_freq_pd`

## Requirements
- R1: While rst_n is low, phase_err is 0, tune_word is mid-scale (32768), bank_code is 128, dith_bit is 0 and dco_code is 128.
- R2: The first ref_stb after reset only captures the phase sample. phase_err and tune_word keep their reset values.
- R3: The sampled phase is dco_cnt·64 plus a 6-bit fraction. The fraction is floor(tdc_code·64 / tdc_period). It is forced to 63 when tdc_code ≥ tdc_period and to 0 when tdc_period is 0.
- R4: The measured frequency is the phase difference taken modulo 2^18, so a wrap of dco_cnt from 4095 to 0 yields the true small step.
- R5: On every ref_stb after the first, phase_err (signed) increases by the measured frequency minus fcw. Without ref_stb, phase_err and tune_word hold.
- R6: On an update, the integrator becomes integ − (phase_err_new >>> ki_shift), clipped to [0, 65535]. tune_word becomes integ_new − (phase_err_new >>> kp_shift), clipped to [0, 65535]. Both results appear one clock after the strobe edge.
- R7: One clock after tune_word changes, bank_code equals tune_word[15:8].
- R8: dith_bit is the carry of an 8-bit accumulator that adds tune_word[7:0] every clock. Over any 256 consecutive clocks with a constant tune_word, dith_bit is 1 exactly tune_word[7:0] times. A zero fraction gives no carry.
- R9: dco_code always equals bank_code + dith_bit, 9 bits wide, without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; the dither modulator advances every cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe marking a reference sample |
| dco_cnt | input | 12 | Free-running oscillator edge count |
| tdc_code | input | 8 | Delay stages traversed since the last oscillator edge |
| tdc_period | input | 8 | Delay stages in one oscillator period |
| fcw | input | 18 | Target frequency, oscillator periods per reference, 6 fraction bits |
| kp_shift | input | 4 | Proportional gain as a right shift |
| ki_shift | input | 4 | Integral gain as a right shift |
| phase_err | output | 24 | Accumulated signed phase error |
| tune_word | output | 16 | Filter output, 8 integer bits and 8 fraction bits |
| bank_code | output | 8 | Integer capacitor-bank code |
| dith_bit | output | 1 | Delta-sigma carry |
| dco_code | output | 9 | bank_code plus dith_bit |

## Verification
Corrupt state inside the block shows up at phase_err on the very next strobe. A stale previous phase, a wrong fraction or a wrong wrap each add a fixed offset to the error step, and that offset persists because the error is integrated. A wrong integrator or clip shows up in tune_word in the same cycle as the error. A bad bank register shows one clock later. A faulty dither accumulator is only exposed by counting carries over a full 256-cycle window, so the bench counts the carries over that window.

// File: rtl/adpll_freq_pd.sv
module adpll_freq_pd #(
  parameter int CNT_W  = 12,
  parameter int TDC_W  = 8,
  parameter int FRAC_W = 6,
  parameter int ERR_W  = 24,
  parameter int BANK_W = 8,
  parameter int DFR_W  = 8,
  localparam int PH_W   = CNT_W + FRAC_W,
  localparam int TUNE_W = BANK_W + DFR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_stb,
  input  logic [CNT_W-1:0]         dco_cnt,
  input  logic [TDC_W-1:0]         tdc_code,
  input  logic [TDC_W-1:0]         tdc_period,
  input  logic [PH_W-1:0]          fcw,
  input  logic [3:0]               kp_shift,
  input  logic [3:0]               ki_shift,
  output logic signed [ERR_W-1:0]  phase_err,
  output logic [TUNE_W-1:0]        tune_word,
  output logic [BANK_W-1:0]        bank_code,
  output logic                     dith_bit,
  output logic [BANK_W:0]          dco_code
);
  localparam int SC_W = TDC_W + FRAC_W;
  localparam int IW   = ERR_W + 2;
  localparam logic [TUNE_W-1:0] MID = TUNE_W'(1) << (TUNE_W - 1);

  logic [SC_W-1:0]          scaled, quot;
  logic [FRAC_W-1:0]        frac;
  logic [PH_W-1:0]          phase_now, phase_prev, meas;
  logic signed [PH_W:0]     ferr;
  logic signed [ERR_W-1:0]  pe_next;
  logic [TUNE_W-1:0]        integ, integ_new, tune_new;
  logic signed [IW-1:0]     i_sum, t_sum;
  logic                     primed;
  logic [DFR_W-1:0]         acc;
  logic [DFR_W:0]           dsum;

  function automatic logic [TUNE_W-1:0] clip(input logic signed [IW-1:0] v);
    if (v < 0) return '0;
    if (v > $signed(IW'({TUNE_W{1'b1}}))) return '1;
    return v[TUNE_W-1:0];
  endfunction

  assign scaled = {tdc_code, FRAC_W'(0)};
  assign quot   = (tdc_period == '0) ? '0 : scaled / SC_W'(tdc_period);
  assign frac   = (tdc_period == '0) ? '0 :
                  (tdc_code >= tdc_period) ? '1 : quot[FRAC_W-1:0];

  assign phase_now = {dco_cnt, frac};
  assign meas      = phase_now - phase_prev;
  assign ferr      = $signed({1'b0, meas}) - $signed({1'b0, fcw});
  assign pe_next   = phase_err + ERR_W'(ferr);

  assign i_sum     = $signed(IW'(integ)) - IW'(pe_next >>> ki_shift);
  assign integ_new = clip(i_sum);
  assign t_sum     = $signed(IW'(integ_new)) - IW'(pe_next >>> kp_shift);
  assign tune_new  = clip(t_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed     <= 1'b0;
      phase_prev <= '0;
      phase_err  <= '0;
      integ      <= MID;
      tune_word  <= MID;
    end else if (ref_stb) begin
      primed     <= 1'b1;
      phase_prev <= phase_now;
      if (primed) begin
        phase_err <= pe_next;
        integ     <= integ_new;
        tune_word <= tune_new;
      end
    end
  end

  assign dsum = {1'b0, acc} + {1'b0, tune_word[DFR_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      dith_bit  <= 1'b0;
      bank_code <= MID[TUNE_W-1:DFR_W];
    end else begin
      acc       <= dsum[DFR_W-1:0];
      dith_bit  <= dsum[DFR_W];
      bank_code <= tune_word[TUNE_W-1:DFR_W];
    end
  end

  assign dco_code = {1'b0, bank_code} + (BANK_W+1)'(dith_bit);
endmodule

// File: rtl/adpll_freq_pd_chk.sv
module adpll_freq_pd_chk #(
  parameter int ERR_W  = 24,
  parameter int BANK_W = 8,
  parameter int DFR_W  = 8,
  localparam int TUNE_W = BANK_W + DFR_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_stb,
  input logic signed [ERR_W-1:0] phase_err,
  input logic [TUNE_W-1:0]       tune_word,
  input logic [BANK_W-1:0]       bank_code,
  input logic                    dith_bit
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else if (ref_stb) seen <= 1'b1;

  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb && !seen |=> $stable(phase_err) && $stable(tune_word)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_stb |=> $stable(phase_err) && $stable(tune_word)); // R5

  AST_BANK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> bank_code == $past(tune_word[TUNE_W-1:DFR_W])); // R7

  AST_NO_CARRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tune_word[DFR_W-1:0] == '0 |=> !dith_bit); // R8
endmodule

bind adpll_freq_pd adpll_freq_pd_chk #(.ERR_W(ERR_W), .BANK_W(BANK_W), .DFR_W(DFR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .phase_err(phase_err),
  .tune_word(tune_word), .bank_code(bank_code), .dith_bit(dith_bit));

// File: tb/test_adpll_freq_pd.sv
module test_adpll_freq_pd;
  localparam int CLK_P = 10;
  localparam int NV = 5;
  localparam int V_CNT [NV] = '{100, 110, 120, 130, 139};
  localparam int V_TDC [NV] = '{0, 0, 16, 16, 48};
  localparam int V_PE  [NV] = '{0, 0, 16, 16, -16};
  localparam int V_TUNE[NV] = '{32768, 32768, 32748, 32744, 32780};

  logic clk = 0, rst_n = 0, ref_stb = 0;
  logic [11:0] dco_cnt = 0;
  logic [7:0]  tdc_code = 0, tdc_period = 64;
  logic [17:0] fcw = 640;
  logic [3:0]  kp_shift = 0, ki_shift = 2;
  logic signed [23:0] phase_err;
  logic [15:0] tune_word;
  logic [7:0]  bank_code;
  logic        dith_bit;
  logic [8:0]  dco_code;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  adpll_freq_pd i_adpll_freq_pd (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .dco_cnt(dco_cnt),
    .tdc_code(tdc_code), .tdc_period(tdc_period), .fcw(fcw),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .phase_err(phase_err),
    .tune_word(tune_word), .bank_code(bank_code), .dith_bit(dith_bit),
    .dco_code(dco_code));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ref_stb = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic strobe(input int cnt, input int tdc);
    @(negedge clk);
    dco_cnt = 12'(cnt); tdc_code = 8'(tdc); ref_stb = 1;
    @(negedge clk);
    ref_stb = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ones;
    @(negedge clk); @(negedge clk);
    chk("R1 phase_err", int'(phase_err), 0);
    chk("R1 tune_word", int'(tune_word), 32768);
    chk("R1 bank_code", int'(bank_code), 128);
    chk("R1 dith_bit", int'(dith_bit), 0);
    chk("R1 dco_code", int'(dco_code), 128);
    rst_n = 1;

    // R2 R3 R5 R6: table walk, first row is the capture-only strobe
    for (int i = 0; i < NV; i++) begin
      strobe(V_CNT[i], V_TDC[i]);
      chk(i == 0 ? "R2 phase_err" : "R5 phase_err", int'(phase_err), V_PE[i]);
      chk(i == 0 ? "R2 tune_word" : "R6 tune_word", int'(tune_word), V_TUNE[i]);
    end

    // R7 R8 R9: constant tune 0x800C
    repeat (3) @(negedge clk);
    ones = 0;
    for (int c = 0; c < 256; c++) begin
      if (dco_code != 9'(bank_code) + 9'(dith_bit)) chk("R9 dco_code", int'(dco_code), int'(bank_code) + int'(dith_bit));
      ones += int'(dith_bit);
      @(negedge clk);
    end
    chk("R7 bank_code", int'(bank_code), 128);
    chk("R8 carry count", ones, 12);
    chk("R5 hold phase_err", int'(phase_err), -16);
    chk("R5 hold tune_word", int'(tune_word), 32780);

    // R4 wrap
    do_reset();
    strobe(4090, 0);
    strobe(4, 0);
    chk("R4 wrap phase_err", int'(phase_err), 0);
    chk("R4 wrap tune_word", int'(tune_word), 32768);

    // R3 normalization with period 128
    do_reset();
    tdc_period = 128;
    strobe(0, 0);
    strobe(10, 64);
    chk("R3 scaled phase_err", int'(phase_err), 32);
    chk("R6 scaled tune_word", int'(tune_word), 32728);

    // R3 clamp and zero period
    do_reset();
    tdc_period = 64;
    strobe(0, 0);
    strobe(10, 100);
    chk("R3 clamp phase_err", int'(phase_err), 63);
    tdc_period = 0;
    strobe(20, 50);
    chk("R3 zero period phase_err", int'(phase_err), 0);

    // R6 low clip
    do_reset();
    tdc_period = 64; fcw = 0; ki_shift = 0; kp_shift = 0;
    strobe(0, 0);
    strobe(4000, 0);
    chk("R5 big phase_err", int'(phase_err), 256000);
    chk("R6 low clip", int'(tune_word), 0);
    @(negedge clk); @(negedge clk);
    chk("R7 bank low", int'(bank_code), 0);
    chk("R9 dco low", int'(dco_code), 0);

    // R6 high clip, R9 no wrap at top
    do_reset();
    fcw = 200000;
    strobe(0, 0);
    strobe(0, 0);
    chk("R6 high clip", int'(tune_word), 65535);
    @(negedge clk);
    ones = 0;
    for (int c = 0; c < 256; c++) begin
      if (dco_code != 9'(bank_code) + 9'(dith_bit)) chk("R9 top dco_code", int'(dco_code), int'(bank_code) + int'(dith_bit));
      ones += int'(dith_bit);
      @(negedge clk);
    end
    chk("R7 bank high", int'(bank_code), 255);
    chk("R8 carry count high", ones, 255);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule